// File: doc/BRIEF.md
# Paged Register Bank CPU Interface

This block is the processor-facing register front end of a bus interface controller. A host reaches a small register file through a three-bit offset, an active-low chip enable, an active-low write strobe and a read-direction strobe. The block turns each access into a one-hot write enable and a read-data value. The registers behind the decode are simple storage stubs. One slot is the data-out register. Reading the data-in offset returns that slot, as a loopback.

There are two register maps. In the legacy map, one offset is empty until an auxiliary page-in command fills it with one of the extra registers. That extra register then stays there until another page-in or a reset. In the overlay map, a page-in makes the chosen extra register cover an existing offset, and the cover ends as soon as the next processor access finishes. A separate DMA grant bypasses the offset decode and goes straight to the data register. During DMA the read-direction strobe has the opposite polarity. Auxiliary commands arrive on the write-data bus, qualified by a strobe.

Top module: `paged_regbank`

## Requirements
- R1: After reset the legacy map is selected, the page is invalid with ID 0, and `rd_data` and `wr_en` are zero.
- R2: A processor write (`ce_n`=0, `we_n`=0, `acc_gr_n`=1) to a mapped offset raises exactly the `wr_en` bit of that register. Offsets 1..7 are slots 1..7, and offset 0 is slot 0 (data out). A processor read (`ce_n`=0, `we_n`=1, `dbin`=1) returns the stored value in the same cycle, and offset 0 returns slot 0.
- R3: In the legacy map, offset 2 has no register while no page is valid. After auxiliary code 0xE0+k (k < 4), offset 2 reaches extra register k, which is `wr_en` bit 8+k. The page stays valid across any number of accesses.
- R4: In the legacy map, a later page-in replaces the paged register. Reset removes the page.
- R5: In the overlay map, a page-in of k makes offset 4+k reach extra register k. The base register at that offset is neither read nor written, and other offsets keep their normal targets.
- R6: In the overlay map, the page becomes invalid in the cycle after chip enable returns high. From then on offset 4+k reaches its base register again.
- R7: While `acc_gr_n`=0, `we_n`=0 writes slot 0 whatever `rs` and `ce_n` are. With `we_n`=1, `dbin`=0 reads slot 0 and `dbin`=1 reads zero.
- R8: Auxiliary code 0xF1 selects the overlay map and 0xF0 the legacy map. Both clear the page. Any other code outside 0xE0..0xE3 changes nothing.
- R9: Unmapped offsets read zero and raise no write enable. These are offset 7 in the legacy map and offset 3 in the overlay map.
- R10: With `ce_n`=1 and `acc_gr_n`=1, `wr_en` and `rd_data` are zero.
- R11: In the overlay map, DMA cycles do not end a valid page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs | input | 3 | Register offset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| dbin | input | 1 | Read-direction strobe (inverted during DMA) |
| acc_gr_n | input | 1 | DMA grant, active low |
| wdata | input | 8 | Write data and auxiliary command code |
| aux_stb | input | 1 | Auxiliary command strobe |
| rd_data | output | 8 | Read data, zero when nothing is read |
| wr_en | output | 12 | One-hot register write enables (0..7 base, 8..11 extra) |
| map_sel | output | 1 | Current map, 1 = overlay |
| page_valid | output | 1 | A paged register is mapped |
| page_id | output | 2 | ID of the paged register |

## Verification
The bench targets page lifetime in each map. If the legacy rule were applied in overlay mode, the base register would stay hidden after the access. If the overlay rule were applied in legacy mode, the extra register would vanish after one read. It writes to the empty offset before any page-in, then pages in and reads zero, which shows whether a stray write reached the hidden register. It also checks that a write through the overlay leaves the base register unchanged, and that DMA cycles neither depend on the offset nor end a page.

// File: rtl/pbk_pkg.sv
`timescale 1ns/1ps
package pbk_pkg;
    typedef enum logic {
        MAP_LEGACY  = 1'b0,
        MAP_OVERLAY = 1'b1
    } map_e;

    localparam logic [3:0] AUX_PAGE_TAG    = 4'hE;
    localparam logic [7:0] AUX_MAP_LEGACY  = 8'hF0;
    localparam logic [7:0] AUX_MAP_OVERLAY = 8'hF1;
endpackage

// File: rtl/pbk_page_ctrl.sv
`timescale 1ns/1ps
module pbk_page_ctrl
    import pbk_pkg::*;
#(
    parameter int NPAGE = 4,
    parameter int IDW   = $clog2(NPAGE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           aux_stb,
    input  logic [7:0]     aux_cmd,
    input  logic           ce_n,
    output map_e           mode,
    output logic           page_valid,
    output logic [IDW-1:0] page_id
);
    localparam logic [4:0] NPAGE_V = 5'(NPAGE);

    typedef struct packed {
        map_e           mode;
        logic           valid;
        logic [IDW-1:0] id;
        logic           ce_n_prev;
    } pg_state_t;

    pg_state_t st_d, st_q;
    logic      pagein_hit;
    logic      ce_trail;

    always_comb begin
        st_d           = st_q;
        st_d.ce_n_prev = ce_n;
        pagein_hit     = aux_stb && (aux_cmd[7:4] == AUX_PAGE_TAG)
                         && ({1'b0, aux_cmd[3:0]} < NPAGE_V);
        ce_trail       = !st_q.ce_n_prev && ce_n;

        if (st_q.mode == MAP_OVERLAY && ce_trail) begin
            st_d.valid = 1'b0;
        end
        if (aux_stb && aux_cmd == AUX_MAP_LEGACY) begin
            st_d.mode  = MAP_LEGACY;
            st_d.valid = 1'b0;
        end else if (aux_stb && aux_cmd == AUX_MAP_OVERLAY) begin
            st_d.mode  = MAP_OVERLAY;
            st_d.valid = 1'b0;
        end else if (pagein_hit) begin
            st_d.valid = 1'b1;
            st_d.id    = aux_cmd[IDW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MAP_LEGACY, valid: 1'b0, id: '0, ce_n_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode       = st_q.mode;
    assign page_valid = st_q.valid;
    assign page_id    = st_q.id;

    AST_LEGACY_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MAP_LEGACY && page_valid && !aux_stb) |=> (page_valid && $stable(page_id))); // R3

    AST_OVERLAY_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MAP_OVERLAY && page_valid && !ce_n && !aux_stb) ##1 (ce_n && !aux_stb)
        |=> !page_valid); // R6

    AST_MAP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_stb && aux_cmd == AUX_MAP_OVERLAY) |=> (mode == MAP_OVERLAY && !page_valid)); // R8
endmodule

// File: rtl/pbk_decode.sv
`timescale 1ns/1ps
module pbk_decode
    import pbk_pkg::*;
#(
    parameter int AW           = 3,
    parameter int NPAGE        = 4,
    parameter int IDW          = $clog2(NPAGE),
    parameter int OFS_PAGE_LEG = 2,
    parameter int OFS_HOLE_LEG = 7,
    parameter int OFS_OVL_BASE = 4,
    parameter int OFS_HOLE_OVL = 3,
    parameter int NOFF         = 1 << AW,
    parameter int NREG         = NOFF + NPAGE,
    parameter int TW           = $clog2(NREG)
) (
    input  logic [AW-1:0]  rs,
    input  logic           ce_n,
    input  logic           we_n,
    input  logic           dbin,
    input  logic           acc_gr_n,
    input  map_e           mode,
    input  logic           page_valid,
    input  logic [IDW-1:0] page_id,
    output logic           hit,
    output logic           rd,
    output logic           wr,
    output logic [TW-1:0]  tgt
);
    localparam logic [AW-1:0] PAGE_LEG = AW'(OFS_PAGE_LEG);
    localparam logic [AW-1:0] HOLE_LEG = AW'(OFS_HOLE_LEG);
    localparam logic [AW-1:0] HOLE_OVL = AW'(OFS_HOLE_OVL);

    logic [AW-1:0] ovl_ofs;
    logic [TW-1:0] ext_tgt;
    logic          hit_raw, rd_raw, wr_raw;

    assign ovl_ofs = AW'(OFS_OVL_BASE) + AW'(page_id);
    assign ext_tgt = TW'(NOFF) + TW'(page_id);

    always_comb begin
        hit_raw = 1'b0;
        rd_raw  = 1'b0;
        wr_raw  = 1'b0;
        tgt     = '0;
        if (!acc_gr_n) begin
            hit_raw = 1'b1;
            wr_raw  = !we_n;
            rd_raw  = we_n && !dbin;
        end else if (!ce_n) begin
            wr_raw = !we_n;
            rd_raw = we_n && dbin;
            if (rs == '0) begin
                hit_raw = 1'b1;
            end else if (mode == MAP_LEGACY) begin
                if (rs == PAGE_LEG) begin
                    hit_raw = page_valid;
                    tgt     = ext_tgt;
                end else if (rs != HOLE_LEG) begin
                    hit_raw = 1'b1;
                    tgt     = TW'(rs);
                end
            end else begin
                if (page_valid && rs == ovl_ofs) begin
                    hit_raw = 1'b1;
                    tgt     = ext_tgt;
                end else if (rs != HOLE_OVL) begin
                    hit_raw = 1'b1;
                    tgt     = TW'(rs);
                end
            end
        end
        hit = hit_raw;
        rd  = hit_raw && rd_raw;
        wr  = hit_raw && wr_raw;
    end
endmodule

// File: rtl/pbk_store.sv
`timescale 1ns/1ps
module pbk_store #(
    parameter int NREG = 12,
    parameter int DW   = 8,
    parameter int TW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  logic            wr,
    input  logic [TW-1:0]   tgt,
    input  logic [DW-1:0]   wdata,
    output logic [NREG-1:0] wr_en,
    output logic [DW-1:0]   rd_data
);
    logic [DW-1:0] slot_d [NREG];
    logic [DW-1:0] slot_q [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_wen
        assign wr_en[gi] = wr && (tgt == TW'(gi));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            slot_d[i] = wr_en[i] ? wdata : slot_q[i];
            if (rd && tgt == TW'(i)) begin
                rd_data = slot_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            slot_q[i] <= rst_n ? slot_d[i] : '0;
        end
    end

    AST_WEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)); // R2
endmodule

// File: rtl/paged_regbank.sv
`timescale 1ns/1ps
module paged_regbank
    import pbk_pkg::*;
#(
    parameter int AW           = 3,
    parameter int DW           = 8,
    parameter int NPAGE        = 4,
    parameter int OFS_PAGE_LEG = 2,
    parameter int OFS_HOLE_LEG = 7,
    parameter int OFS_OVL_BASE = 4,
    parameter int OFS_HOLE_OVL = 3,
    parameter int NOFF         = 1 << AW,
    parameter int NREG         = NOFF + NPAGE,
    parameter int IDW          = $clog2(NPAGE),
    parameter int TW           = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rs,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            dbin,
    input  logic            acc_gr_n,
    input  logic [DW-1:0]   wdata,
    input  logic            aux_stb,
    output logic [DW-1:0]   rd_data,
    output logic [NREG-1:0] wr_en,
    output logic            map_sel,
    output logic            page_valid,
    output logic [IDW-1:0]  page_id
);
    map_e          mode;
    logic          dec_hit, dec_rd, dec_wr;
    logic [TW-1:0] dec_tgt;

    pbk_page_ctrl #(.NPAGE(NPAGE), .IDW(IDW)) u_page (
        .clk(clk), .rst_n(rst_n), .aux_stb(aux_stb), .aux_cmd(wdata[7:0]),
        .ce_n(ce_n), .mode(mode), .page_valid(page_valid), .page_id(page_id)
    );

    pbk_decode #(
        .AW(AW), .NPAGE(NPAGE), .IDW(IDW),
        .OFS_PAGE_LEG(OFS_PAGE_LEG), .OFS_HOLE_LEG(OFS_HOLE_LEG),
        .OFS_OVL_BASE(OFS_OVL_BASE), .OFS_HOLE_OVL(OFS_HOLE_OVL),
        .NOFF(NOFF), .NREG(NREG), .TW(TW)
    ) u_dec (
        .rs(rs), .ce_n(ce_n), .we_n(we_n), .dbin(dbin), .acc_gr_n(acc_gr_n),
        .mode(mode), .page_valid(page_valid), .page_id(page_id),
        .hit(dec_hit), .rd(dec_rd), .wr(dec_wr), .tgt(dec_tgt)
    );

    pbk_store #(.NREG(NREG), .DW(DW), .TW(TW)) u_store (
        .clk(clk), .rst_n(rst_n), .rd(dec_rd), .wr(dec_wr), .tgt(dec_tgt),
        .wdata(wdata), .wr_en(wr_en), .rd_data(rd_data)
    );

    assign map_sel = (mode == MAP_OVERLAY);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && acc_gr_n) |-> (wr_en == '0 && rd_data == '0)); // R10

    AST_DMA_WRITE_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_gr_n && !we_n) |-> (wr_en == NREG'(1))); // R7

    AST_LEGACY_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_gr_n && !ce_n && !map_sel && rs == AW'(OFS_HOLE_LEG))
        |-> (wr_en == '0 && rd_data == '0)); // R9

    AST_DMA_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n ##1 (ce_n && !acc_gr_n && !aux_stb && map_sel && page_valid)
        |=> page_valid); // R11
endmodule

// File: tb/paged_regbank_tb.sv
`timescale 1ns/1ps
module paged_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rs = '0;
    logic        ce_n = 1'b1, we_n = 1'b1, dbin = 1'b0, acc_gr_n = 1'b1, aux_stb = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data;
    logic [11:0] wr_en;
    logic        map_sel, page_valid;
    logic [1:0]  page_id;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    paged_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .rs(rs), .ce_n(ce_n), .we_n(we_n), .dbin(dbin),
        .acc_gr_n(acc_gr_n), .wdata(wdata), .aux_stb(aux_stb), .rd_data(rd_data),
        .wr_en(wr_en), .map_sel(map_sel), .page_valid(page_valid), .page_id(page_id)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cpu_wr(input logic [2:0] ofs, input logic [7:0] d, input int exp_en, input string req);
        @(negedge clk); rs = ofs; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        #1 chk(req, int'(wr_en), exp_en);
        @(posedge clk); @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic cpu_rd(input logic [2:0] ofs, input int exp, input string req);
        @(negedge clk); rs = ofs; ce_n = 1'b0; dbin = 1'b1;
        #1 chk(req, int'(rd_data), exp);
        @(posedge clk); @(negedge clk); ce_n = 1'b1; dbin = 1'b0;
        @(posedge clk);
    endtask

    task automatic aux(input logic [7:0] cmd);
        @(negedge clk); aux_stb = 1'b1; wdata = cmd;
        @(posedge clk); @(negedge clk); aux_stb = 1'b0;
        @(posedge clk);
    endtask

    task automatic chk_state(input string req, input int m, input int v, input int id);
        @(negedge clk); #1;
        chk({req, " map"}, int'(map_sel), m);
        chk({req, " valid"}, int'(page_valid), v);
        chk({req, " id"}, int'(page_id), id);
    endtask

    task automatic t_reset;
        chk_state("R1", 0, 0, 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 wr_en", int'(wr_en), 0);
    endtask

    task automatic t_basic_rw;
        cpu_wr(3'd1, 8'h11, 12'h002, "R2 wen ofs1");
        cpu_wr(3'd5, 8'h55, 12'h020, "R2 wen ofs5");
        cpu_wr(3'd0, 8'hA5, 12'h001, "R2 wen ofs0");
        cpu_rd(3'd1, 8'h11, "R2 read ofs1");
        cpu_rd(3'd5, 8'h55, "R2 read ofs5");
        cpu_rd(3'd0, 8'hA5, "R2 read ofs0 loopback");
    endtask

    task automatic t_idle;
        @(negedge clk); ce_n = 1'b1; acc_gr_n = 1'b1; we_n = 1'b0; dbin = 1'b1; rs = 3'd1;
        #1 chk("R10 idle wen", int'(wr_en), 0);
        chk("R10 idle rd", int'(rd_data), 0);
        @(negedge clk); we_n = 1'b1; dbin = 1'b0;
    endtask

    task automatic t_legacy_page;
        cpu_rd(3'd2, 0, "R3 empty ofs2 read");
        cpu_wr(3'd2, 8'h77, 0, "R3 empty ofs2 write");
        cpu_wr(3'd7, 8'h88, 0, "R9 legacy hole write");
        cpu_rd(3'd7, 0, "R9 legacy hole read");
        aux(8'hE1);
        chk_state("R3 page-in", 0, 1, 1);
        cpu_rd(3'd2, 0, "R3 ext1 untouched by earlier write");
        cpu_wr(3'd2, 8'h3C, 12'h200, "R3 ext1 wen");
        cpu_rd(3'd1, 8'h11, "R3 other offset");
        cpu_rd(3'd2, 8'h3C, "R3 ext1 persists");
        chk_state("R3 still valid", 0, 1, 1);
    endtask

    task automatic t_legacy_replace;
        aux(8'hE3);
        chk_state("R4 replaced", 0, 1, 3);
        cpu_rd(3'd2, 0, "R4 ext3 read");
        cpu_wr(3'd2, 8'hC3, 12'h800, "R4 ext3 wen");
        aux(8'hE1);
        cpu_rd(3'd2, 8'h3C, "R4 back to ext1");
    endtask

    task automatic t_aux_ignored;
        aux(8'hE7);
        chk_state("R8 bad page code", 0, 1, 1);
        aux(8'h42);
        chk_state("R8 unknown code", 0, 1, 1);
    endtask

    task automatic t_overlay;
        aux(8'hF1);
        chk_state("R8 overlay select", 1, 0, 1);
        cpu_wr(3'd6, 8'h66, 12'h040, "R5 base6 write");
        aux(8'hE2);
        chk_state("R5 page-in", 1, 1, 2);
        cpu_wr(3'd6, 8'h99, 12'h400, "R5 overlay wen ext2");
        chk_state("R6 expired", 1, 0, 2);
        cpu_rd(3'd6, 8'h66, "R5 base6 untouched");
        aux(8'hE2);
        cpu_rd(3'd6, 8'h99, "R5 overlay read ext2");
        cpu_rd(3'd6, 8'h66, "R6 base after expiry");
        aux(8'hE2);
        cpu_rd(3'd5, 8'h55, "R5 other offset normal");
        chk_state("R6 expired after other access", 1, 0, 2);
        cpu_wr(3'd3, 8'h33, 0, "R9 overlay hole write");
        cpu_rd(3'd3, 0, "R9 overlay hole read");
    endtask

    task automatic t_dma;
        aux(8'hE0);
        @(negedge clk); acc_gr_n = 1'b0; ce_n = 1'b1; we_n = 1'b0; rs = 3'd5; wdata = 8'h5A;
        #1 chk("R7 dma write slot0", int'(wr_en), 12'h001);
        @(negedge clk); we_n = 1'b1; dbin = 1'b0; rs = 3'd6;
        #1 chk("R7 dma read", int'(rd_data), 8'h5A);
        @(negedge clk); dbin = 1'b1;
        #1 chk("R7 dma dbin high", int'(rd_data), 0);
        @(negedge clk); acc_gr_n = 1'b1; dbin = 1'b0;
        chk_state("R11 page kept", 1, 1, 0);
        cpu_rd(3'd0, 8'h5A, "R7 cpu sees dma data");
        chk_state("R11 ends on cpu access", 1, 0, 0);
    endtask

    task automatic t_back_and_reset;
        aux(8'hF0);
        chk_state("R8 legacy select", 0, 0, 0);
        cpu_rd(3'd2, 0, "R8 offset2 empty again");
        aux(8'hF1);
        aux(8'hE3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk_state("R4 reset clears page", 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_basic_rw();
        t_idle();
        t_legacy_page();
        t_legacy_replace();
        t_aux_ignored();
        t_overlay();
        t_dma();
        t_back_and_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule